// File: doc/BRIEF.md
# DMA Channel Event Status and Interrupt Register Unit

This unit is the status corner of a 16-channel DMA controller. Each channel's datapath raises single-cycle strobes when a transfer finishes or when one of four fault conditions occurs: burst timeout, request timeout, transfer error or buffer overflow. The unit latches these strobes into per-channel sticky bits and presents them to software through a small word-addressed register window. Every sticky bit is cleared by writing 1 to it. A fault always marks the channel in the pending register as well as in its own fault register, so software must clear both.

A per-channel mask decides which pending bits can raise the interrupt line, where 1 blocks and 0 passes. A separate error line is raised while any fault bit in any channel is set. A global control register holds the module enable, which is passed out to the channel datapaths, and a self-clearing soft reset. A burst-timeout control register holds an enable and a 15-bit limit, which are also driven out to the datapaths. Register reads are combinational. A write takes effect at the clock edge on which `bus_wr` is high, and the register access has no handshake.

Top module: `dma_irq_status_regs`

## Requirements
- R1: After `rst_n` is asserted, every status and fault register reads 0, the mask reads 0xFFFF, control and burst-timeout control read 0, and `irq_o`, `err_irq_o`, `soft_rst_o`, `core_en_o` and `bto_en_o` are low.
- R2: A 1 on `ev_done[i]` at a clock edge sets bit i of the pending register (offset 0x04) from that edge onward.
- R3: A 1 on bit i of a fault strobe sets bit i of that fault's register and also bit i of the pending register. The fault registers are burst timeout at 0x0C, request timeout at 0x10, transfer error at 0x14 and buffer overflow at 0x18.
- R4: Writing to the pending register or to a fault register clears exactly the bits written as 1 and leaves all other bits unchanged. Clearing a fault register does not touch the pending register.
- R5: If a strobe and a write-1 clear hit the same bit on the same edge, the bit stays set.
- R6: The mask register (offset 0x08) reads back all 16 written bits. `irq_o` is high exactly when some channel has its pending bit set and its mask bit at 0.
- R7: `err_irq_o` is high exactly when at least one bit of the four fault registers is set.
- R8: In the control register (offset 0x00), bit 0 is the module enable and drives `core_en_o`. Writing 1 to bit 1 clears every status and fault bit, sets every mask bit, and clears the enable and the burst-timeout control. That write takes priority over any strobe and over the other bits written with it. `soft_rst_o` is high, and control bit 1 reads 1, for exactly the one cycle after that write.
- R9: In the burst-timeout control register (offset 0x1C), bit 15 is the enable, driven on `bto_en_o`, and bits 14:0 are the limit, driven on `bto_limit_o`. Both read back as written.
- R10: An address whose two low bits are not 00 reads 0 and its writes change nothing. Control bits 15:2 read 0 whatever was written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Byte address of the register access |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| ev_done | input | 16 | Per-channel completion strobes |
| ev_burst_to | input | 16 | Per-channel burst-timeout strobes |
| ev_req_to | input | 16 | Per-channel request-timeout strobes |
| ev_xfer_err | input | 16 | Per-channel transfer-error strobes |
| ev_buf_ovf | input | 16 | Per-channel buffer-overflow strobes |
| irq_o | output | 1 | Channel interrupt: a pending bit that the mask does not block |
| err_irq_o | output | 1 | Fault interrupt: any fault bit set |
| core_en_o | output | 1 | Module enable to the channel datapaths |
| soft_rst_o | output | 1 | One-cycle soft reset pulse to the channel datapaths |
| bto_en_o | output | 1 | Burst-timeout enable |
| bto_limit_o | output | 15 | Burst-timeout limit |

## Verification
The hardest cases to reach are those where two sources act on the same bit on the same edge. One is a strobe landing on the edge where software writes 1 to clear that bit. The other is a fault strobe landing on the edge of a soft-reset write. The stimulus raises the strobe inputs before it issues the write task, so both act on one edge. The registers are then read back to show which source won. The one-cycle soft reset pulse is checked in the cycle right after the write, before any later access can hide it.

// File: rtl/dis_pkg.sv
package dis_pkg;
  localparam int REG_COUNT = 8;
  localparam int IDX_W     = 3;
  localparam int ERR_KINDS = 4;

  // Word index of each register; byte offset is index * 4.
  typedef enum logic [IDX_W-1:0] {
    RI_CTRL     = 3'd0,
    RI_PEND     = 3'd1,
    RI_MASK     = 3'd2,
    RI_BURST_TO = 3'd3,
    RI_REQ_TO   = 3'd4,
    RI_XFER_ERR = 3'd5,
    RI_BUF_OVF  = 3'd6,
    RI_BTO_CTL  = 3'd7
  } reg_idx_e;

  // Fault register slots, in the order of their word indices.
  localparam int FK_BURST_TO = 0;
  localparam int FK_REQ_TO   = 1;
  localparam int FK_XFER_ERR = 2;
  localparam int FK_BUF_OVF  = 3;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_SRST_BIT = 1;
endpackage

// File: rtl/dis_addr_decode.sv
module dis_addr_decode
  import dis_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  output logic                 hit,
  output reg_idx_e             idx,
  output logic [REG_COUNT-1:0] wr_sel
);
  localparam int IDX_LSB = 2;
  localparam int IDX_MSB = IDX_LSB + IDX_W - 1;

  logic upper_zero;

  generate
    if (ADDR_W > IDX_MSB + 1) begin : g_hi
      assign upper_zero = (bus_addr[ADDR_W-1:IDX_MSB+1] == '0);
    end else begin : g_nohi
      assign upper_zero = 1'b1;
    end
  endgenerate

  assign hit = upper_zero && (bus_addr[IDX_LSB-1:0] == '0);
  assign idx = reg_idx_e'(bus_addr[IDX_MSB:IDX_LSB]);

  always_comb begin
    wr_sel = '0;
    if (bus_wr && hit) wr_sel[idx] = 1'b1;
  end
endmodule

// File: rtl/dis_w1c_bank.sv
module dis_w1c_bank #(
  parameter int CH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          srst,
  input  logic [CH-1:0] set,
  input  logic          clr_en,
  input  logic [CH-1:0] clr_bits,
  output logic [CH-1:0] q
);
  // Priority per bit: soft reset, then a strobe, then a write-1 clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      for (int i = 0; i < CH; i++) begin
        if (srst)                     q[i] <= 1'b0;
        else if (set[i])              q[i] <= 1'b1;
        else if (clr_en && clr_bits[i]) q[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dis_ctrl_regs.sv
module dis_ctrl_regs
  import dis_pkg::*;
#(
  parameter int CH    = 16,
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ctrl,
  input  logic             wr_mask,
  input  logic             wr_bto,
  input  logic [1:0]       ctrl_wdata,
  input  logic [CH-1:0]    mask_wdata,
  input  logic [CNT_W:0]   bto_wdata,
  output logic             srst_req,
  output logic             srst_q,
  output logic             en_q,
  output logic [CH-1:0]    mask_q,
  output logic             bto_en_q,
  output logic [CNT_W-1:0] bto_cnt_q
);
  assign srst_req = wr_ctrl && ctrl_wdata[CTRL_SRST_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srst_q    <= 1'b0;
      en_q      <= 1'b0;
      mask_q    <= '1;
      bto_en_q  <= 1'b0;
      bto_cnt_q <= '0;
    end else if (srst_req) begin
      srst_q    <= 1'b1;
      en_q      <= 1'b0;
      mask_q    <= '1;
      bto_en_q  <= 1'b0;
      bto_cnt_q <= '0;
    end else begin
      srst_q <= 1'b0;
      if (wr_ctrl) en_q <= ctrl_wdata[CTRL_EN_BIT];
      if (wr_mask) mask_q <= mask_wdata;
      if (wr_bto) begin
        bto_en_q  <= bto_wdata[CNT_W];
        bto_cnt_q <= bto_wdata[CNT_W-1:0];
      end
    end
  end
endmodule

// File: rtl/dis_read_mux.sv
module dis_read_mux
  import dis_pkg::*;
#(
  parameter int CH     = 16,
  parameter int CNT_W  = 15,
  parameter int DATA_W = 16
) (
  input  logic                          hit,
  input  reg_idx_e                      idx,
  input  logic                          srst_q,
  input  logic                          en_q,
  input  logic [CH-1:0]                 pend_q,
  input  logic [CH-1:0]                 mask_q,
  input  logic [ERR_KINDS-1:0][CH-1:0]  err_q,
  input  logic                          bto_en_q,
  input  logic [CNT_W-1:0]              bto_cnt_q,
  output logic [DATA_W-1:0]             rdata
);
  always_comb begin
    rdata = '0;
    if (hit) begin
      unique case (idx)
        RI_CTRL:     rdata = DATA_W'({srst_q, en_q});
        RI_PEND:     rdata = DATA_W'(pend_q);
        RI_MASK:     rdata = DATA_W'(mask_q);
        RI_BURST_TO: rdata = DATA_W'(err_q[FK_BURST_TO]);
        RI_REQ_TO:   rdata = DATA_W'(err_q[FK_REQ_TO]);
        RI_XFER_ERR: rdata = DATA_W'(err_q[FK_XFER_ERR]);
        RI_BUF_OVF:  rdata = DATA_W'(err_q[FK_BUF_OVF]);
        RI_BTO_CTL:  rdata = DATA_W'({bto_en_q, bto_cnt_q});
        default:     rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/dma_irq_status_regs.sv
module dma_irq_status_regs
  import dis_pkg::*;
#(
  parameter int CH     = 16,
  parameter int CNT_W  = 15,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [CH-1:0]     ev_done,
  input  logic [CH-1:0]     ev_burst_to,
  input  logic [CH-1:0]     ev_req_to,
  input  logic [CH-1:0]     ev_xfer_err,
  input  logic [CH-1:0]     ev_buf_ovf,
  output logic              irq_o,
  output logic              err_irq_o,
  output logic              core_en_o,
  output logic              soft_rst_o,
  output logic              bto_en_o,
  output logic [CNT_W-1:0]  bto_limit_o
);
  logic                         hit;
  reg_idx_e                     idx;
  logic [REG_COUNT-1:0]         wr_sel;
  logic                         srst_req;
  logic                         srst_q;
  logic                         en_q;
  logic [CH-1:0]                mask_q;
  logic [CH-1:0]                pend_q;
  logic [CH-1:0]                pend_set;
  logic [ERR_KINDS-1:0][CH-1:0] err_ev;
  logic [ERR_KINDS-1:0][CH-1:0] err_q;
  logic                         bto_en_q;
  logic [CNT_W-1:0]             bto_cnt_q;

  dis_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .bus_wr  (bus_wr),
    .bus_addr(bus_addr),
    .hit     (hit),
    .idx     (idx),
    .wr_sel  (wr_sel)
  );

  dis_ctrl_regs #(.CH(CH), .CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_ctrl   (wr_sel[RI_CTRL]),
    .wr_mask   (wr_sel[RI_MASK]),
    .wr_bto    (wr_sel[RI_BTO_CTL]),
    .ctrl_wdata(bus_wdata[1:0]),
    .mask_wdata(bus_wdata[CH-1:0]),
    .bto_wdata (bus_wdata[CNT_W:0]),
    .srst_req  (srst_req),
    .srst_q    (srst_q),
    .en_q      (en_q),
    .mask_q    (mask_q),
    .bto_en_q  (bto_en_q),
    .bto_cnt_q (bto_cnt_q)
  );

  assign err_ev[FK_BURST_TO] = ev_burst_to;
  assign err_ev[FK_REQ_TO]   = ev_req_to;
  assign err_ev[FK_XFER_ERR] = ev_xfer_err;
  assign err_ev[FK_BUF_OVF]  = ev_buf_ovf;

  // A fault on a channel marks it pending as well.
  always_comb begin
    pend_set = ev_done;
    for (int k = 0; k < ERR_KINDS; k++) pend_set = pend_set | err_ev[k];
  end

  dis_w1c_bank #(.CH(CH)) u_pend (
    .clk     (clk),
    .rst_n   (rst_n),
    .srst    (srst_req),
    .set     (pend_set),
    .clr_en  (wr_sel[RI_PEND]),
    .clr_bits(bus_wdata[CH-1:0]),
    .q       (pend_q)
  );

  generate
    for (genvar k = 0; k < ERR_KINDS; k++) begin : g_err
      dis_w1c_bank #(.CH(CH)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .srst    (srst_req),
        .set     (err_ev[k]),
        .clr_en  (wr_sel[int'(RI_BURST_TO) + k]),
        .clr_bits(bus_wdata[CH-1:0]),
        .q       (err_q[k])
      );
    end
  endgenerate

  dis_read_mux #(.CH(CH), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_rmux (
    .hit      (hit),
    .idx      (idx),
    .srst_q   (srst_q),
    .en_q     (en_q),
    .pend_q   (pend_q),
    .mask_q   (mask_q),
    .err_q    (err_q),
    .bto_en_q (bto_en_q),
    .bto_cnt_q(bto_cnt_q),
    .rdata    (bus_rdata)
  );

  assign irq_o       = |(pend_q & ~mask_q);
  assign err_irq_o   = |err_q;
  assign core_en_o   = en_q;
  assign soft_rst_o  = srst_q;
  assign bto_en_o    = bto_en_q;
  assign bto_limit_o = bto_cnt_q;
endmodule

// File: rtl/dis_status_chk.sv
module dis_status_chk #(
  parameter int CH     = 16,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [CH-1:0]     ev_done,
  input logic [CH-1:0]     ev_burst_to,
  input logic [CH-1:0]     ev_req_to,
  input logic [CH-1:0]     ev_xfer_err,
  input logic [CH-1:0]     ev_buf_ovf,
  input logic [CH-1:0]     pend_q,
  input logic [CH-1:0]     mask_q,
  input logic              soft_rst_o,
  input logic              irq_o,
  input logic              err_irq_o
);
  logic          srst_wr;
  logic          pend_wr;
  logic [CH-1:0] any_ev;

  assign srst_wr = bus_wr && (bus_addr == ADDR_W'(0)) && bus_wdata[1];
  assign pend_wr = bus_wr && (bus_addr == ADDR_W'(4));
  assign any_ev  = ev_done | ev_burst_to | ev_req_to | ev_xfer_err | ev_buf_ovf;

  // R2
  done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|ev_done) && !srst_wr) |=> ((pend_q & $past(ev_done)) == $past(ev_done)));

  // R3
  fault_marks_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|ev_xfer_err) && !srst_wr) |=> ((pend_q & $past(ev_xfer_err)) == $past(ev_xfer_err)));

  // R4
  w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_wr && (any_ev == '0)) |=> ((pend_q & $past(bus_wdata[CH-1:0])) == '0));

  // R5
  event_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_wr && !srst_wr && ((ev_done & bus_wdata[CH-1:0]) != '0))
      |=> ((pend_q & $past(ev_done & bus_wdata[CH-1:0])) != '0));

  // R6
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ((pend_q != '0) && (mask_q != '1)));

  // R7
  err_rise_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_irq_o) |-> (pend_q != '0));

  // R8
  srst_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_o |-> ((pend_q == '0) && (mask_q == '1) && !irq_o && !err_irq_o));

  // R8
  srst_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_rst_o && !srst_wr) |=> !soft_rst_o);
endmodule

bind dma_irq_status_regs dis_status_chk #(
  .CH(CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .ev_done    (ev_done),
  .ev_burst_to(ev_burst_to),
  .ev_req_to  (ev_req_to),
  .ev_xfer_err(ev_xfer_err),
  .ev_buf_ovf (ev_buf_ovf),
  .pend_q     (pend_q),
  .mask_q     (mask_q),
  .soft_rst_o (soft_rst_o),
  .irq_o      (irq_o),
  .err_irq_o  (err_irq_o)
);

// File: tb/sim_dma_irq_status_regs.sv
module sim_dma_irq_status_regs;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 20000;

  localparam int K_RD = 0, K_IRQ = 1, K_ERR = 2, K_EN = 3, K_SRST = 4,
                 K_BTOEN = 5, K_BTOCNT = 6;

  typedef struct {
    int          kind;
    logic [15:0] exp;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [15:0] ev_done = '0, ev_burst_to = '0, ev_req_to = '0,
               ev_xfer_err = '0, ev_buf_ovf = '0;
  logic        irq_o, err_irq_o, core_en_o, soft_rst_o, bto_en_o;
  logic [14:0] bto_limit_o;

  item_t sb[$];
  int    n_vec = 0;
  int    n_bad = 0;
  bit    done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_irq_status_regs u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_done(ev_done),
    .ev_burst_to(ev_burst_to), .ev_req_to(ev_req_to),
    .ev_xfer_err(ev_xfer_err), .ev_buf_ovf(ev_buf_ovf), .irq_o(irq_o),
    .err_irq_o(err_irq_o), .core_en_o(core_en_o), .soft_rst_o(soft_rst_o),
    .bto_en_o(bto_en_o), .bto_limit_o(bto_limit_o)
  );

  // Monitor: pops expected items and compares at the falling edge.
  always @(negedge clk) begin : mon
    item_t       it;
    logic [15:0] act;
    while (sb.size() != 0) begin
      it = sb.pop_front();
      case (it.kind)
        K_RD:     act = bus_rdata;
        K_IRQ:    act = {15'd0, irq_o};
        K_ERR:    act = {15'd0, err_irq_o};
        K_EN:     act = {15'd0, core_en_o};
        K_SRST:   act = {15'd0, soft_rst_o};
        K_BTOEN:  act = {15'd0, bto_en_o};
        default:  act = {1'b0, bto_limit_o};
      endcase
      n_vec++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s kind=%0d addr=0x%02h actual=0x%04h expected=0x%04h",
                 it.tag, it.kind, bus_addr, act, it.exp);
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic settle();
    @(negedge clk); #1;
  endtask

  task automatic expect_out(input int kind, input logic [15:0] e, input string tag);
    item_t it;
    it.kind = kind; it.exp = e; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic rd(input logic [4:0] a, input logic [15:0] e, input string tag);
    bus_addr = a;
    expect_out(K_RD, e, tag);
    settle();
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic pulse(input logic [15:0] d, input logic [15:0] bt,
                       input logic [15:0] rt, input logic [15:0] xe,
                       input logic [15:0] bo);
    ev_done = d; ev_burst_to = bt; ev_req_to = rt; ev_xfer_err = xe; ev_buf_ovf = bo;
    tick();
    ev_done = '0; ev_burst_to = '0; ev_req_to = '0; ev_xfer_err = '0; ev_buf_ovf = '0;
  endtask

  initial begin : watchdog
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();

    // R1: reset state of every register and output
    expect_out(K_IRQ, 0, "R1"); expect_out(K_ERR, 0, "R1");
    expect_out(K_SRST, 0, "R1"); expect_out(K_EN, 0, "R1");
    expect_out(K_BTOEN, 0, "R1");
    rd(5'h00, 16'h0000, "R1");
    rd(5'h04, 16'h0000, "R1");
    rd(5'h08, 16'hFFFF, "R1");
    rd(5'h0C, 16'h0000, "R1");
    rd(5'h10, 16'h0000, "R1");
    rd(5'h14, 16'h0000, "R1");
    rd(5'h18, 16'h0000, "R1");
    rd(5'h1C, 16'h0000, "R1");

    // R2: completion strobes on channels 3 and 15
    pulse(16'h8008, 0, 0, 0, 0);
    expect_out(K_IRQ, 0, "R6");
    rd(5'h04, 16'h8008, "R2");

    // R6: unmask channel 3
    wr(5'h08, 16'hFFF7);
    expect_out(K_IRQ, 1, "R6");
    rd(5'h08, 16'hFFF7, "R6");

    // R4: write-1 clear of bit 3, then a write of zeros
    wr(5'h04, 16'h0008);
    expect_out(K_IRQ, 0, "R6");
    rd(5'h04, 16'h8000, "R4");
    wr(5'h04, 16'h0000);
    rd(5'h04, 16'h8000, "R4");

    // R3: transfer error on channel 5 marks both registers
    pulse(0, 0, 0, 16'h0020, 0);
    expect_out(K_ERR, 1, "R7");
    rd(5'h14, 16'h0020, "R3");
    rd(5'h04, 16'h8020, "R3");

    // R3: other three fault kinds on channels 0, 1, 2
    pulse(0, 16'h0001, 16'h0002, 0, 16'h0004);
    rd(5'h0C, 16'h0001, "R3");
    rd(5'h10, 16'h0002, "R3");
    rd(5'h18, 16'h0004, "R3");
    rd(5'h04, 16'h8027, "R3");

    // R4: clearing a fault register leaves pending untouched
    wr(5'h14, 16'h0020);
    rd(5'h14, 16'h0000, "R4");
    rd(5'h04, 16'h8027, "R4");
    expect_out(K_ERR, 1, "R7");
    settle();

    // R7: error line drops once all faults are cleared
    wr(5'h0C, 16'hFFFF);
    wr(5'h10, 16'hFFFF);
    wr(5'h18, 16'hFFFF);
    expect_out(K_ERR, 0, "R7");
    rd(5'h04, 16'h8027, "R4");

    // R5: strobe and clear on the same edge, pending and fault register
    ev_done = 16'h0010;
    wr(5'h04, 16'h0010);
    ev_done = '0;
    rd(5'h04, 16'h8037, "R5");
    ev_req_to = 16'h0100;
    wr(5'h10, 16'h0100);
    ev_req_to = '0;
    rd(5'h10, 16'h0100, "R5");
    rd(5'h04, 16'h8137, "R5");
    wr(5'h04, 16'hFFFF);
    rd(5'h04, 16'h0000, "R4");
    expect_out(K_ERR, 1, "R7");
    settle();

    // R8: module enable
    wr(5'h00, 16'h0001);
    expect_out(K_EN, 1, "R8");
    rd(5'h00, 16'h0001, "R8");
    // R10: reserved control bits read zero
    wr(5'h00, 16'hFFFD);
    rd(5'h00, 16'h0001, "R10");

    // R9: burst-timeout control
    wr(5'h1C, 16'h9234);
    expect_out(K_BTOEN, 1, "R9");
    expect_out(K_BTOCNT, 16'h1234, "R9");
    rd(5'h1C, 16'h9234, "R9");
    wr(5'h1C, 16'h7FFF);
    expect_out(K_BTOEN, 0, "R9");
    expect_out(K_BTOCNT, 16'h7FFF, "R9");
    rd(5'h1C, 16'h7FFF, "R9");

    // R10: misaligned write ignored, misaligned read is zero
    wr(5'h09, 16'h0000);
    rd(5'h08, 16'hFFF7, "R10");
    rd(5'h0A, 16'h0000, "R10");

    // R8: soft reset beats a simultaneous fault strobe
    pulse(16'h0008, 0, 0, 0, 0);
    expect_out(K_IRQ, 1, "R6");
    settle();
    ev_xfer_err = 16'h0002;
    wr(5'h00, 16'h0003);
    ev_xfer_err = '0;
    expect_out(K_SRST, 1, "R8");
    expect_out(K_IRQ, 0, "R8");
    expect_out(K_ERR, 0, "R8");
    expect_out(K_EN, 0, "R8");
    expect_out(K_BTOEN, 0, "R8");
    rd(5'h00, 16'h0002, "R8");
    expect_out(K_SRST, 0, "R8");
    rd(5'h04, 16'h0000, "R8");
    rd(5'h08, 16'hFFFF, "R8");
    rd(5'h10, 16'h0000, "R8");
    rd(5'h14, 16'h0000, "R8");
    rd(5'h1C, 16'h0000, "R8");
    rd(5'h00, 16'h0000, "R8");

    settle();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule